// File: doc/BRIEF.md
# Accumulator Processor with Compare-and-Branch

A compact single-accumulator processor that runs one instruction per clock from a unified 64-word RAM holding both program and data. Its instruction set covers loading, adding, storing and dividing through the accumulator, a memory-to-memory compare that records a less-than flag, a conditional jump that consults that flag, and an end instruction that stops execution.

The RAM lives inside the block and is filled from outside while reset is held. After reset is released the processor starts at address 0 and keeps running until it executes an end instruction. It then freezes its state and raises `halted`. Debug outputs expose the address and word of the last executed instruction, the accumulator, the less-than flag and a sticky divide-by-zero flag, so that the whole machine state can be observed after every step.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, `dbg_pc`, `dbg_ir`, `dbg_acc`, `dbg_lt`, `dbg_div_err` and `halted` become 0, and the first instruction after release is fetched from address 0.
- R2: Each clock edge with `rst` low and `halted` low completes exactly one instruction. An instruction word is 16 bits: opcode in [15:12], operand field A in [11:6], operand field B in [5:0]; single-operand instructions use field B. After the step, `dbg_ir` holds the executed word and `dbg_pc` its address, and except for a taken jump the next fetch comes from that address plus one.
- R3: LOAD (opcode 1) copies RAM[B] into the accumulator; ADD (opcode 2) adds RAM[B] to the accumulator modulo 2^16.
- R4: STORE (opcode 3) writes the accumulator into RAM[B], so that a later LOAD of B returns it; the accumulator is unchanged.
- R5: DIV (opcode 6) replaces the accumulator with the unsigned integer quotient accumulator / RAM[B]. When RAM[B] is 0 the accumulator keeps its value and `dbg_div_err` is set; that flag stays set until reset.
- R6: CMP (opcode 4) sets `dbg_lt` to 1 when RAM[A] < RAM[B] as unsigned values and to 0 otherwise (equal gives 0), leaving the accumulator unchanged; no other instruction changes `dbg_lt`.
- R7: JL (opcode 5) makes the next fetch come from address B when `dbg_lt` is 1, and from the next address otherwise.
- R8: END (opcode 0) and any opcode from 7 to 15 stop execution: `halted` goes to 1 in the same step, and from then on `dbg_pc`, `dbg_ir`, `dbg_acc`, `dbg_lt` and `dbg_div_err` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| halted | output | 1 | High once an end instruction has executed |
| dbg_pc | output | 6 | Address of the last executed instruction |
| dbg_ir | output | 16 | Word of the last executed instruction |
| dbg_acc | output | 16 | Accumulator |
| dbg_lt | output | 1 | Less-than flag from the most recent compare |
| dbg_div_err | output | 1 | Sticky divide-by-zero flag |

## Verification
The assertions assume that the RAM is only written from outside while `rst` is high, so that the word fetched and the operands read in a step come solely from reset contents and earlier STORE results. The bench fills memory exclusively inside its reset window and releases reset on a falling edge, before the first execution edge. Programs are laid out so that every path ends on an end word, which keeps the halt-hold property reachable and the runs bounded.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 6;
    localparam int OP_W    = 4;
    localparam int INSTR_W = OP_W + 2 * ADDR_W;
    localparam int N_OPND  = 2;

    typedef enum logic [OP_W-1:0] {
        OP_END   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_ADD   = 4'd2,
        OP_STORE = 4'd3,
        OP_CMP   = 4'd4,
        OP_JL    = 4'd5,
        OP_DIV   = 4'd6
    } opcode_t;

    localparam logic [OP_W-1:0] OP_LAST = 4'd6;

    typedef struct packed {
        opcode_t           op;
        logic [ADDR_W-1:0] fa;
        logic [ADDR_W-1:0] fb;
    } instr_t;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              lt;
        logic              err;
    } exec_state_t;

    // Undefined opcodes fold onto END so the core stops on them.
    function automatic instr_t decode_word(input logic [INSTR_W-1:0] w);
        instr_t d;
        d = instr_t'(w);
        if (w[INSTR_W-1 -: OP_W] > OP_LAST) begin
            d.op = OP_END;
        end
        return d;
    endfunction

    function automatic logic is_sequential(input opcode_t op);
        return (op != OP_END) && (op != OP_JL);
    endfunction

endpackage

// File: rtl/acc_ram.sv
module acc_ram #(
    parameter int DW  = 16,
    parameter int AW  = 6,
    parameter int NOP = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] faddr,
    output logic [DW-1:0] fdata,
    input  logic [AW-1:0] oaddr [NOP],
    output logic [DW-1:0] odata [NOP]
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign fdata = mem[faddr];

    generate
        for (genvar g = 0; g < NOP; g++) begin : g_oport
            assign odata[g] = mem[oaddr[g]];
        end
    endgenerate
endmodule

// File: rtl/acc_fetch.sv
module acc_fetch
    import acc_cpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] word,
    input  instr_t             cur,
    input  logic               lt,
    output logic [ADDR_W-1:0]  fetch_pc,
    output logic [ADDR_W-1:0]  exec_pc,
    output logic [INSTR_W-1:0] ir,
    output logic               halted
);
    logic [ADDR_W-1:0] pc_q, xpc_q;
    logic [INSTR_W-1:0] ir_q;
    logic halt_q;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        unique case (cur.op)
            OP_END:  pc_d = pc_q;
            OP_JL:   pc_d = lt ? cur.fb : pc_q + ADDR_W'(1);
            default: pc_d = pc_q + ADDR_W'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            xpc_q  <= '0;
            ir_q   <= '0;
            halt_q <= 1'b0;
        end else if (!halt_q) begin
            pc_q   <= pc_d;
            xpc_q  <= pc_q;
            ir_q   <= word;
            halt_q <= (cur.op == OP_END);
        end
    end

    assign fetch_pc = pc_q;
    assign exec_pc  = xpc_q;
    assign ir       = ir_q;
    assign halted   = halt_q;
endmodule

// File: rtl/acc_exec.sv
module acc_exec
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  instr_t            cur,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output exec_state_t       state,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data
);
    exec_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        unique case (cur.op)
            OP_LOAD: s_d.acc = opnd_b;
            OP_ADD:  s_d.acc = s_q.acc + opnd_b;
            OP_CMP:  s_d.lt  = (opnd_a < opnd_b);
            OP_DIV: begin
                if (opnd_b == '0) begin
                    s_d.err = 1'b1;
                end else begin
                    s_d.acc = s_q.acc / opnd_b;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else if (run) begin
            s_q <= s_d;
        end
    end

    assign state   = s_q;
    assign st_we   = run && !rst && (cur.op == OP_STORE);
    assign st_addr = cur.fb;
    assign st_data = s_q.acc;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic               halted,
    output logic [ADDR_W-1:0]  dbg_pc,
    output logic [INSTR_W-1:0] dbg_ir,
    output logic [DATA_W-1:0]  dbg_acc,
    output logic               dbg_lt,
    output logic               dbg_div_err
);
    logic [ADDR_W-1:0]  fetch_pc;
    logic [INSTR_W-1:0] word;
    instr_t             cur;
    opcode_t            cur_op;
    logic [ADDR_W-1:0]  cur_fb;
    logic               run;
    logic [ADDR_W-1:0]  oaddr [N_OPND];
    logic [DATA_W-1:0]  odata [N_OPND];
    exec_state_t        state;
    logic               st_we;
    logic [ADDR_W-1:0]  st_addr;
    logic [DATA_W-1:0]  st_data;

    assign cur      = decode_word(word);
    assign cur_op   = cur.op;
    assign cur_fb   = cur.fb;
    assign oaddr[0] = cur.fa;
    assign oaddr[1] = cur.fb;
    assign run      = !halted;

    acc_ram #(.DW(DATA_W), .AW(ADDR_W), .NOP(N_OPND)) u_ram (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_addr),
        .wdata (st_data),
        .faddr (fetch_pc),
        .fdata (word),
        .oaddr (oaddr),
        .odata (odata)
    );

    acc_fetch u_fetch (
        .clk      (clk),
        .rst      (rst),
        .word     (word),
        .cur      (cur),
        .lt       (state.lt),
        .fetch_pc (fetch_pc),
        .exec_pc  (dbg_pc),
        .ir       (dbg_ir),
        .halted   (halted)
    );

    acc_exec u_exec (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .cur     (cur),
        .opnd_a  (odata[0]),
        .opnd_b  (odata[1]),
        .state   (state),
        .st_we   (st_we),
        .st_addr (st_addr),
        .st_data (st_data)
    );

    assign dbg_acc     = state.acc;
    assign dbg_lt      = state.lt;
    assign dbg_div_err = state.err;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               run,
    input opcode_t            op,
    input logic [ADDR_W-1:0]  target,
    input logic [ADDR_W-1:0]  fetch_pc,
    input logic [ADDR_W-1:0]  dbg_pc,
    input logic [INSTR_W-1:0] dbg_ir,
    input logic [DATA_W-1:0]  dbg_acc,
    input logic               dbg_lt,
    input logic               dbg_div_err,
    input logic               halted
);
    // R2: a non-jump, non-end step leaves the fetch one past the executed address
    a_r2_seq_next: assert property (@(posedge clk) disable iff (rst)
        (run && is_sequential(op)) |=> (fetch_pc == dbg_pc + ADDR_W'(1)));

    // R5: divide error flag is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        dbg_div_err |=> dbg_div_err);

    // R6: compare leaves the accumulator alone
    a_r6_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (run && op == OP_CMP) |=> $stable(dbg_acc));

    // R6: only a compare moves the less-than flag
    a_r6_lt_only_cmp: assert property (@(posedge clk) disable iff (rst)
        (run && op != OP_CMP) |=> $stable(dbg_lt));

    // R7: taken jump lands on its target
    a_r7_jl_taken: assert property (@(posedge clk) disable iff (rst)
        (run && op == OP_JL && dbg_lt) |=> (fetch_pc == $past(target)));

    // R8: halted state is frozen
    a_r8_halt_hold: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(dbg_pc) && $stable(dbg_ir)
                    && $stable(dbg_acc) && $stable(dbg_lt)));
endmodule

bind acc_cpu acc_cpu_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .op          (cur_op),
    .target      (cur_fb),
    .fetch_pc    (fetch_pc),
    .dbg_pc      (dbg_pc),
    .dbg_ir      (dbg_ir),
    .dbg_acc     (dbg_acc),
    .dbg_lt      (dbg_lt),
    .dbg_div_err (dbg_div_err),
    .halted      (halted)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halted;
    logic [5:0]  dbg_pc;
    logic [15:0] dbg_ir;
    logic [15:0] dbg_acc;
    logic        dbg_lt;
    logic        dbg_div_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_cpu u0 (
        .clk(clk), .rst(rst), .halted(halted), .dbg_pc(dbg_pc),
        .dbg_ir(dbg_ir), .dbg_acc(dbg_acc), .dbg_lt(dbg_lt),
        .dbg_div_err(dbg_div_err)
    );

    typedef struct packed {
        logic [1:0]  prog;
        logic        fresh;
        logic [15:0] ir;
        logic [5:0]  pc;
        logic [15:0] acc;
        logic        lt;
        logic        err;
        logic        hlt;
    } row_t;

    localparam int NR = 29;
    // prog 0: averaging, prog 1: compare and jump taken, prog 2: corner cases
    localparam row_t ROWS [NR] = '{
        '{2'd0, 1'b1, 16'h1008, 6'd0,  16'd8,  1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h2009, 6'd1,  16'd10, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h300C, 6'd2,  16'd10, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h100C, 6'd3,  16'd10, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h200A, 6'd4,  16'd21, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h300C, 6'd5,  16'd21, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h100C, 6'd6,  16'd21, 1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h600B, 6'd7,  16'd7,  1'b0, 1'b0, 1'b0},
        '{2'd0, 1'b0, 16'h0008, 6'd8,  16'd7,  1'b0, 1'b0, 1'b1},
        '{2'd0, 1'b0, 16'h0008, 6'd8,  16'd7,  1'b0, 1'b0, 1'b1},
        '{2'd1, 1'b1, 16'h1006, 6'd0,  16'd2,  1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b0, 16'h2008, 6'd1,  16'd7,  1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b0, 16'h3008, 6'd2,  16'd7,  1'b0, 1'b0, 1'b0},
        '{2'd1, 1'b0, 16'h4209, 6'd3,  16'd7,  1'b1, 1'b0, 1'b0},
        '{2'd1, 1'b0, 16'h500B, 6'd4,  16'd7,  1'b1, 1'b0, 1'b0},
        '{2'd1, 1'b0, 16'h0000, 6'd11, 16'd7,  1'b1, 1'b0, 1'b1},
        '{2'd2, 1'b1, 16'h1014, 6'd0,  16'd100, 1'b0, 1'b0, 1'b0},
        '{2'd2, 1'b0, 16'h4556, 6'd1,  16'd100, 1'b0, 1'b0, 1'b0},
        '{2'd2, 1'b0, 16'h500A, 6'd2,  16'd100, 1'b0, 1'b0, 1'b0},
        '{2'd2, 1'b0, 16'h4595, 6'd3,  16'd100, 1'b1, 1'b0, 1'b0},
        '{2'd2, 1'b0, 16'h6017, 6'd4,  16'd100, 1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b0, 16'h6018, 6'd5,  16'd14, 1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b0, 16'h2019, 6'd6,  16'd3,  1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b0, 16'h301A, 6'd7,  16'd3,  1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b0, 16'h101B, 6'd8,  16'd0,  1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b0, 16'h101A, 6'd9,  16'd3,  1'b1, 1'b1, 1'b0},
        '{2'd2, 1'b0, 16'h4555, 6'd10, 16'd3,  1'b0, 1'b1, 1'b0},
        '{2'd2, 1'b0, 16'hF000, 6'd11, 16'd3,  1'b0, 1'b1, 1'b1},
        '{2'd2, 1'b0, 16'hF000, 6'd11, 16'd3,  1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic load_prog(input int p);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) u0.u_ram.mem[i] = 16'h0000;
        case (p)
            0: begin
                u0.u_ram.mem[0] = 16'h1008; u0.u_ram.mem[1] = 16'h2009;
                u0.u_ram.mem[2] = 16'h300C; u0.u_ram.mem[3] = 16'h100C;
                u0.u_ram.mem[4] = 16'h200A; u0.u_ram.mem[5] = 16'h300C;
                u0.u_ram.mem[6] = 16'h100C; u0.u_ram.mem[7] = 16'h600B;
                u0.u_ram.mem[8] = 16'd8;    u0.u_ram.mem[9] = 16'd2;
                u0.u_ram.mem[10] = 16'd11;  u0.u_ram.mem[11] = 16'd3;
            end
            1: begin
                u0.u_ram.mem[0] = 16'h1006; u0.u_ram.mem[1] = 16'h2008;
                u0.u_ram.mem[2] = 16'h3008; u0.u_ram.mem[3] = 16'h4209;
                u0.u_ram.mem[4] = 16'h500B; u0.u_ram.mem[6] = 16'd2;
                u0.u_ram.mem[7] = 16'd5;    u0.u_ram.mem[8] = 16'd5;
                u0.u_ram.mem[9] = 16'd15;
            end
            default: begin
                u0.u_ram.mem[0] = 16'h1014; u0.u_ram.mem[1] = 16'h4556;
                u0.u_ram.mem[2] = 16'h500A; u0.u_ram.mem[3] = 16'h4595;
                u0.u_ram.mem[4] = 16'h6017; u0.u_ram.mem[5] = 16'h6018;
                u0.u_ram.mem[6] = 16'h2019; u0.u_ram.mem[7] = 16'h301A;
                u0.u_ram.mem[8] = 16'h101B; u0.u_ram.mem[9] = 16'h101A;
                u0.u_ram.mem[10] = 16'h4555; u0.u_ram.mem[11] = 16'hF000;
                u0.u_ram.mem[20] = 16'd100; u0.u_ram.mem[21] = 16'd9;
                u0.u_ram.mem[22] = 16'd4;   u0.u_ram.mem[23] = 16'd0;
                u0.u_ram.mem[24] = 16'd7;   u0.u_ram.mem[25] = 16'hFFF5;
                u0.u_ram.mem[26] = 16'h1234; u0.u_ram.mem[27] = 16'd0;
            end
        endcase
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " R1 pc"},      16'(dbg_pc), 16'd0);
        check({tag, " R1 ir"},      dbg_ir, 16'h0000);
        check({tag, " R1 acc"},     dbg_acc, 16'd0);
        check({tag, " R1 lt"},      16'(dbg_lt), 16'd0);
        check({tag, " R1 err"},     16'(dbg_div_err), 16'd0);
        check({tag, " R1 halted"},  16'(halted), 16'd0);
    endtask

    initial begin
        // table walk: one execution step per row
        for (int r = 0; r < NR; r++) begin
            if (ROWS[r].fresh) begin
                load_prog(int'(ROWS[r].prog));
                #1;
                check_reset_state("after load");
            end
            step();
            check($sformatf("row %0d R2 ir", r), dbg_ir, ROWS[r].ir);
            check($sformatf("row %0d R2 R7 pc", r), 16'(dbg_pc), 16'(ROWS[r].pc));
            check($sformatf("row %0d R3 R4 R5 acc", r), dbg_acc, ROWS[r].acc);
            check($sformatf("row %0d R6 lt", r), 16'(dbg_lt), 16'(ROWS[r].lt));
            check($sformatf("row %0d R5 err", r), 16'(dbg_div_err), 16'(ROWS[r].err));
            check($sformatf("row %0d R8 halted", r), 16'(halted), 16'(ROWS[r].hlt));
        end

        // R1: reset clears flags that were set by the last program
        rst = 1'b1;
        step();
        check_reset_state("reset after errors");

        // R8: long hold after end instruction
        load_prog(0);
        for (int k = 0; k < 30; k++) step();
        check("R8 hold halted", 16'(halted), 16'd1);
        check("R8 hold pc", 16'(dbg_pc), 16'd8);
        check("R8 hold ir", dbg_ir, 16'h0008);
        check("R8 hold acc", dbg_acc, 16'd7);

        // R7: jump not taken when flag clear, then R4 store visible via load
        load_prog(2);
        for (int k = 0; k < 4; k++) step();
        check("R7 not taken pc", 16'(dbg_pc), 16'd3);
        for (int k = 0; k < 6; k++) step();
        check("R4 stored value reloaded", dbg_acc, 16'd3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule